// File: doc/BRIEF.md
# UART Receive Character Buffer with Trigger Interrupt

This block is the receive-side character store of a UART-style peripheral. A receive path or an internal loopback path offers one character per cycle, together with its error and status bits, as a single data word. The block holds accepted words in arrival order. A bus read of the data register takes them out one at a time. An occupancy counter and a read pointer track the contents. The block drives full and empty flags and an accept-ready signal back to the source. It also drives a raw receive interrupt that rises when the occupancy reaches a trigger level.

The capacity can be changed at run time. In buffered mode it holds `DEPTH` words (16 by default). With buffering off it acts as a one-word holding register. Each slot index is the read pointer plus the occupancy, masked by the capacity minus one, so `DEPTH` must be a power of two. A configuration write that changes the mode flushes the contents. The trigger level is a parameter and defaults to one word.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rxIrq` is 0, `acceptReady` is 1 and `modeActive` is 0. `modeActive` = 0 means one-word mode and 1 means buffered mode.
- R2: In one-word mode the capacity is one word. After one accepted push, `full` is 1 and `acceptReady` is 0.
- R3: In buffered mode the capacity is `DEPTH` words. `full` rises on the push that makes the occupancy equal to `DEPTH`, and `acceptReady` is 1 exactly while the occupancy is below the capacity.
- R4: A push while the occupancy equals the capacity is dropped. Contents, flags and occupancy are unchanged.
- R5: `popData` always shows the word at the read pointer. A `popStrobe` clears `full`. When the buffer is not empty, it also removes that word, decrements the occupancy and advances the pointer. `empty` is set when the occupancy after the read is zero.
- R6: A `popStrobe` while empty changes neither the pointer nor the occupancy. `popData` keeps showing the word at the read pointer, and in one-word mode that is the last word stored.
- R7: `rxIrq` is set when an accepted push makes the occupancy equal to `TRIGGER`.
- R8: `rxIrq` is cleared by a `popStrobe` when the occupancy after the read, plus one, equals `TRIGGER`. This includes a read while empty with `TRIGGER` = 1. Reads at other occupancies leave `rxIrq` unchanged.
- R9: A `cfgWrite` whose `cfgFifoEn` differs from `modeActive` switches the mode and flushes the buffer: occupancy and pointer go to 0, `empty` goes to 1 and `full` to 0. `rxIrq` is unchanged. A `cfgWrite` with the current mode value changes nothing.
- R10: A mode-changing `cfgWrite` takes precedence. A push or pop in the same cycle has no effect.
- R11: A push and a pop in the same cycle act as a read followed by a write. The occupancy is unchanged, and with `TRIGGER` = 1 on a one-word occupancy `rxIrq` ends up set.
- R12: Words come out in push order across the wrap of the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Source offers a word this cycle |
| pushData | input | DATA_W | Character with its error and status bits |
| acceptReady | output | 1 | Occupancy below current capacity |
| popStrobe | input | 1 | Data-register read |
| popData | output | DATA_W | Word at the read pointer |
| cfgWrite | input | 1 | Line-configuration write strobe |
| cfgFifoEn | input | 1 | Requested mode: 1 buffered, 0 one-word |
| modeActive | output | 1 | Current mode: 1 buffered, 0 one-word |
| full | output | 1 | Full flag |
| empty | output | 1 | Empty flag |
| rxIrq | output | 1 | Raw receive interrupt |

## Verification
The assertions check on every cycle that `full` and `empty` are never both set and that `full` blocks acceptance. They also check that a dropped push or an empty read leaves the flags and `popData` alone, and that a mode change empties the buffer on the next cycle. Some behaviour needs whole sequences, and only the bench scenarios show it: the push order across a pointer wrap, the exact cycle in which the trigger interrupt sets and clears, the combined push and pop, and the loss of a push or pop that coincides with a mode change.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  // Strobes from the control to the storage datapath.
  typedef struct packed {
    logic wrEn;      // store pushData at the write slot
    logic rdAdv;     // advance the read pointer
    logic ptrClear;  // flush: read pointer back to zero
  } storeCmd_t;
endpackage

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int CNT_W   = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popStrobe,
  input  logic             cfgWrite,
  input  logic             cfgFifoEn,
  output storeCmd_t        cmd,
  output logic [PTR_W-1:0] capMask,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             acceptReady,
  output logic             rxIrq,
  output logic             modeActive
);
  localparam logic [CNT_W-1:0] CAP_BUF  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TRIG_LVL = CNT_W'(TRIGGER);

  logic             modeFifo;
  logic [CNT_W-1:0] capacity;
  logic [CNT_W-1:0] cntMid;
  logic             modeFlip, roomLeft, popTaken, pushTaken;
  logic             popClear, pushSet;

  always_comb begin
    capacity  = modeFifo ? CAP_BUF : CAP_ONE;
    capMask   = modeFifo ? PTR_W'(DEPTH - 1) : '0;
    modeFlip  = cfgWrite && (cfgFifoEn != modeFifo);
    roomLeft  = count < capacity;
    popTaken  = popStrobe && !modeFlip && (count != '0);
    cntMid    = count - CNT_W'(popTaken);
    pushTaken = pushValid && roomLeft && !modeFlip;
    popClear  = popStrobe && !modeFlip && ((cntMid + CAP_ONE) == TRIG_LVL);
    pushSet   = pushTaken && ((cntMid + CAP_ONE) == TRIG_LVL);
    cmd.wrEn     = pushTaken;
    cmd.rdAdv    = popTaken;
    cmd.ptrClear = modeFlip;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      full     <= 1'b0;
      empty    <= 1'b1;
      rxIrq    <= 1'b0;
      modeFifo <= 1'b0;
    end else begin
      rxIrq <= pushSet | (rxIrq & ~popClear);
      if (modeFlip) begin
        count    <= '0;
        full     <= 1'b0;
        empty    <= 1'b1;
        modeFifo <= cfgFifoEn;
      end else begin
        count <= cntMid + CNT_W'(pushTaken);
        if (pushTaken)
          full <= (cntMid + CAP_ONE) == capacity;
        else if (popStrobe)
          full <= 1'b0;
        if (pushTaken)
          empty <= 1'b0;
        else if (popStrobe && cntMid == '0)
          empty <= 1'b1;
      end
    end
  end

  assign acceptReady = roomLeft;
  assign modeActive  = modeFifo;
endmodule

// File: rtl/rxfifo_store.sv
module rxfifo_store
  import rxfifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCmd_t         cmd,
  input  logic [PTR_W-1:0]  capMask,
  input  logic [PTR_W-1:0]  cntLow,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrSlot;

  assign wrSlot = (rdPtr + cntLow) & capMask;

  always_ff @(posedge clk) begin
    if (!rstN)
      rdPtr <= '0;
    else if (cmd.ptrClear)
      rdPtr <= '0;
    else if (cmd.rdAdv)
      rdPtr <= (rdPtr + PTR_W'(1)) & capMask;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        slots[g] <= '0;
      else if (cmd.wrEn && wrSlot == PTR_W'(g))
        slots[g] <= wrData;
    end
  end

  assign rdData = slots[rdPtr];
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxfifo_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int DEPTH   = 16,
  parameter int TRIGGER = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              acceptReady,
  input  logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  input  logic              cfgWrite,
  input  logic              cfgFifoEn,
  output logic              modeActive,
  output logic              full,
  output logic              empty,
  output logic              rxIrq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  storeCmd_t        cmd;
  logic [PTR_W-1:0] capMask;
  logic [CNT_W-1:0] count;

  rxfifo_ctrl #(.DEPTH(DEPTH), .TRIGGER(TRIGGER), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
    .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn), .cmd(cmd), .capMask(capMask),
    .count(count), .full(full), .empty(empty), .acceptReady(acceptReady),
    .rxIrq(rxIrq), .modeActive(modeActive)
  );

  rxfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd), .capMask(capMask),
    .cntLow(count[PTR_W-1:0]), .wrData(pushData), .rdData(popData)
  );
endmodule

// File: rtl/rx_char_fifo_chk.sv
module rx_char_fifo_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              popStrobe,
  input logic              cfgWrite,
  input logic              cfgFifoEn,
  input logic              modeActive,
  input logic              acceptReady,
  input logic              full,
  input logic              empty,
  input logic [DATA_W-1:0] popData
);
  // R5: flags are exclusive
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  // R3: a full buffer refuses input
  a_r3_full_blocks_accept: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !acceptReady);

  // R4: a push into a full buffer is dropped
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && pushValid && !popStrobe && !cfgWrite) |=> (full && $stable(popData)));

  // R6: a read while empty changes nothing
  a_r6_empty_read_idle: assert property (@(posedge clk) disable iff (!rstN)
    (empty && popStrobe && !pushValid && !cfgWrite) |=> (empty && $stable(popData)));

  // R9: a mode change empties the buffer
  a_r9_flush_on_mode: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgFifoEn != modeActive) |=> (empty && !full && modeActive == $past(cfgFifoEn)));
endmodule

bind rx_char_fifo rx_char_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .popStrobe(popStrobe),
  .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn), .modeActive(modeActive),
  .acceptReady(acceptReady), .full(full), .empty(empty), .popData(popData)
);

// File: tb/tb_rx_char_fifo.sv
module tb_rx_char_fifo;
  localparam int DW = 12;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, popStrobe = 1'b0, cfgWrite = 1'b0, cfgFifoEn = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic acceptReady, modeActive, full, empty, rxIrq;
  logic [DW-1:0] popData;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int capModel = 1;
  logic [DW-1:0] sb[$];

  always #4 clk = ~clk;

  rx_char_fifo #(.DATA_W(DW), .DEPTH(DEP), .TRIGGER(1)) dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .acceptReady(acceptReady), .popStrobe(popStrobe), .popData(popData),
    .cfgWrite(cfgWrite), .cfgFifoEn(cfgFifoEn), .modeActive(modeActive),
    .full(full), .empty(empty), .rxIrq(rxIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic stepClk();
    @(posedge clk);
    @(negedge clk);
    pushValid = 0; popStrobe = 0; cfgWrite = 0;
  endtask

  task automatic checkFlags(input string tag);
    check({tag, " empty"}, 32'(empty), 32'(sb.size() == 0));
    check({tag, " full"}, 32'(full), 32'(sb.size() == capModel));
    check({tag, " acceptReady"}, 32'(acceptReady), 32'(sb.size() < capModel));
  endtask

  // driver: model pushes into scoreboard only when room exists
  task automatic drvPush(input logic [DW-1:0] d);
    pushValid = 1; pushData = d;
    if (sb.size() < capModel) sb.push_back(d);
    stepClk();
  endtask

  // monitor side: compare the head before the read consumes it
  task automatic drvPop(input string tag);
    if (sb.size() > 0) begin
      check(tag, 32'(popData), 32'(sb[0]));
      void'(sb.pop_front());
    end
    popStrobe = 1;
    stepClk();
  endtask

  task automatic setMode(input logic v);
    cfgWrite = 1; cfgFifoEn = v;
    if (v != modeActive) sb.delete();
    capModel = v ? DEP : 1;
    stepClk();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(empty), 1);
    check("R1 full", 32'(full), 0);
    check("R1 rxIrq", 32'(rxIrq), 0);
    check("R1 acceptReady", 32'(acceptReady), 1);
    check("R1 modeActive", 32'(modeActive), 0);

    // R2 one-word mode, R7 trigger on first word
    drvPush(12'h0A1);
    checkFlags("R2");
    check("R7 irq after push", 32'(rxIrq), 1);
    // R4 push into full holding register dropped
    drvPush(12'h0B2);
    checkFlags("R4");
    check("R4 data kept", 32'(popData), 32'h0A1);
    // R5 read, R8 irq cleared
    drvPop("R5 one-word read");
    checkFlags("R5");
    check("R8 irq cleared", 32'(rxIrq), 0);
    // R6 empty read returns last word, no state change
    drvPop("R6 empty read");
    check("R6 popData", 32'(popData), 32'h0A1);
    checkFlags("R6");

    // R9 switch to buffered mode
    setMode(1);
    check("R9 modeActive", 32'(modeActive), 1);
    checkFlags("R9");
    for (int i = 0; i < DEP; i++) begin
      drvPush(12'(32'h100 + i));
      if (i == 0) check("R7 irq at first", 32'(rxIrq), 1);
      if (i == DEP - 2) checkFlags("R3 one short");
    end
    checkFlags("R3 full");
    drvPush(12'h3FF);
    checkFlags("R4 buffered drop");
    for (int i = 0; i < 3; i++) drvPop("R5 ordered read");
    check("R8 irq kept", 32'(rxIrq), 1);
    for (int i = 0; i < 3; i++) drvPush(12'(32'h200 + i));
    checkFlags("R12 refill");
    for (int i = 0; i < DEP; i++) begin
      if (i == DEP - 1) check("R8 irq before last", 32'(rxIrq), 1);
      drvPop("R12 wrap order");
    end
    checkFlags("R5 drained");
    check("R8 irq after last", 32'(rxIrq), 0);
    // R6 empty read in buffered mode: slot 3 holds 0x103
    check("R6 stale slot", 32'(popData), 32'h103);
    drvPop("R6 empty read buffered");
    check("R6 stale slot after", 32'(popData), 32'h103);
    checkFlags("R6 buffered");

    // R11 push and pop together
    drvPush(12'h055);
    check("R11 head", 32'(popData), 32'h055);
    pushValid = 1; pushData = 12'h066; popStrobe = 1;
    void'(sb.pop_front()); sb.push_back(12'h066);
    stepClk();
    checkFlags("R11");
    check("R11 irq", 32'(rxIrq), 1);
    check("R11 new head", 32'(popData), 32'h066);
    drvPop("R11 read");

    // R9 same-mode write does not flush
    drvPush(12'h077);
    setMode(1);
    checkFlags("R9 no flush");
    check("R9 data kept", 32'(popData), 32'h077);
    drvPop("R9 read");

    // R10 mode change beats push and pop
    drvPush(12'h088);
    check("R10 irq before", 32'(rxIrq), 1);
    pushValid = 1; pushData = 12'h099; popStrobe = 1;
    setMode(0);
    checkFlags("R10 flushed");
    check("R10 mode", 32'(modeActive), 0);
    check("R9 irq unchanged", 32'(rxIrq), 1);
    drvPush(12'h0C3);
    checkFlags("R10 after push");
    drvPop("R10 fresh word");
    check("R8 irq final", 32'(rxIrq), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule